// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one channel of a compare-match timer. A 32-bit up-counter advances on a count clock derived from a slow-clock tick input. The tick can be used undivided or divided by 8, 32 or 128. The count runs only while the run enable, which comes from a shared start/stop register outside the channel, is high. A compare register sets the point at which a match event occurs. In periodic mode the counter restarts from zero after the match. In free-running mode it carries on past the match and sets an overflow flag when it rolls over from all-ones to zero.

Software reaches three registers through a write strobe, a 2-bit register select, write data and a combinational read bus. Select 0 is the control/status register, select 1 is the counter and select 2 is the compare value. Select 3 reads zero and ignores writes. Each match event can be routed to a level interrupt or to a one-cycle DMA request pulse. The two status flags are cleared by writing zero to them. A write to the counter is held pending and takes effect only after two further slow-clock ticks.

Top module: `cmatch_timer`

## Requirements
- R1: After reset, the control/status register (select 0) reads 0, the counter (select 1) reads 0, the compare register (select 2) reads 0xFFFFFFFF, and irq and dma_req are low.
- R2: While run_en is low the counter keeps its value, whatever the slow_tick input does.
- R3: Clock-select field bits [2:0] of the control/status register: code 4 advances the counter on every 8th slow tick, code 5 on every 32nd, code 6 on every 128th and code 7 on every slow tick. Only ticks seen while run_en is high are counted, and a low run_en restarts the division.
- R4: Periodic mode (bit 8 = 1): when the counter equals the compare value on a count tick, it goes to 0 and the match flag (bit 15) sets. One period is therefore compare+1 count ticks. Compare writes take effect at once.
- R5: Free-running mode (bit 8 = 0): the match flag sets when the counter passes the compare value, and counting continues to compare+1. A count tick at 0xFFFFFFFF goes to 0 and sets the overflow flag (bit 14).
- R6: Writing a control/status value with 0 in bit 15 or bit 14 clears that flag. Writing 1 leaves the flag unchanged. Bits 13..9, 6 and 3 read as 0.
- R7: A counter write changes neither the counter nor its read value until two slow ticks after the write cycle. The new value appears in the cycle after the second such tick.
- R8: irq is high exactly while the match flag is set, bit 7 is 1 and routing bits [5:4] equal 10.
- R9: With routing bits [5:4] equal to 01, each match event drives dma_req high for exactly the one cycle that follows the event.
- R10: Writing 0 to the control/status register clears both flags and turns off irq and dma_req.
- R11: Clock-select codes 0 to 3 stop the counter.
- R12: If a match event and a write that clears the match flag fall in the same cycle, the flag ends up set.
- R13: A counter load that becomes due on a tick takes priority over counting in that cycle, and no match or overflow event occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Channel run enable from the shared start/stop register |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control/status, 1 counter, 2 compare |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register (combinational) |
| irq | output | 1 | Level interrupt request |
| dma_req | output | 1 | One-cycle DMA request pulse |

## Verification
The sharpest collision is a hardware match setting the match flag in the same cycle that software writes zero to that flag. The bench provokes it by letting the counter reach the compare value and then issuing the clearing control write together with the slow tick that makes the match. The flag must read back as set. A second collision, a pending counter load that falls on a count tick, is provoked by writing the counter while it runs. The bench judges it by reading the loaded value in place of the incremented one. Random traffic then mixes both collisions with overflow and DMA events, and the outputs are compared every cycle against a bench model.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  localparam int CSR_W     = 16;
  localparam int MF_BIT    = 15;
  localparam int OF_BIT    = 14;
  localparam int PER_BIT   = 8;
  localparam int IE_BIT    = 7;
  localparam int ROUTE_LSB = 4;
  localparam int CKS_LSB   = 0;

  localparam logic [2:0] CKS_DIV_A = 3'd4;
  localparam logic [2:0] CKS_DIV_B = 3'd5;
  localparam logic [2:0] CKS_DIV_C = 3'd6;
  localparam logic [2:0] CKS_DIV_1 = 3'd7;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'b00,
    ROUTE_DMA  = 2'b01,
    ROUTE_IRQ  = 2'b10,
    ROUTE_RSVD = 2'b11
  } route_e;

  typedef enum logic [1:0] {
    REG_CSR  = 2'b00,
    REG_CNT  = 2'b01,
    REG_CMP  = 2'b10,
    REG_NONE = 2'b11
  } reg_sel_e;

  typedef struct packed {
    logic       periodic;
    logic       irq_en;
    route_e     route;
    logic [2:0] cks;
  } ctrl_t;

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
#(
  parameter int LOG2_A = 3,
  parameter int LOG2_B = 5,
  parameter int LOG2_C = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       slow_tick,
  input  logic [2:0] cks,
  output logic       cnt_tick
);

  localparam int PRE_W = LOG2_C;
  localparam int NTAP  = 3;
  localparam int TAP_LOG2 [NTAP] = '{LOG2_A, LOG2_B, LOG2_C};

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [NTAP-1:0]  tap;
  logic             sel;

  // One terminal-count detector per divider option.
  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam logic [PRE_W-1:0] MASK = PRE_W'((1 << TAP_LOG2[g]) - 1);
    assign tap[g] = ((pre_q & MASK) == MASK);
  end

  always_comb begin
    if (!run_en) begin
      pre_d = '0;
    end else if (slow_tick) begin
      pre_d = pre_q + PRE_W'(1);
    end else begin
      pre_d = pre_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  always_comb begin
    case (cks)
      CKS_DIV_A: sel = tap[0];
      CKS_DIV_B: sel = tap[1];
      CKS_DIV_C: sel = tap[2];
      CKS_DIV_1: sel = 1'b1;
      default:   sel = 1'b0;
    endcase
  end

  assign cnt_tick = run_en & slow_tick & sel;

  // R2
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (pre_q == '0));

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W      = 32,
  parameter int LOAD_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             slow_tick,
  input  logic             periodic,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match_evt,
  output logic             ovf_evt
);

  localparam int PEND_W = $clog2(LOAD_TICKS + 1);
  localparam logic [PEND_W-1:0] PEND_START = PEND_W'(LOAD_TICKS);
  localparam logic [PEND_W-1:0] PEND_LAST  = PEND_W'(1);

  logic [CNT_W-1:0]  cnt_d;
  logic [CNT_W-1:0]  pval_q, pval_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              load_now;
  logic              cmp_hit;
  logic              at_max;

  assign load_now  = slow_tick && (pend_q == PEND_LAST);
  assign cmp_hit   = (cnt_q == cmp);
  assign at_max    = &cnt_q;
  assign match_evt = cnt_tick & ~load_now & cmp_hit;
  assign ovf_evt   = cnt_tick & ~load_now & at_max & ~(periodic & cmp_hit);

  always_comb begin
    if (load_now) begin
      cnt_d = pval_q;
    end else if (cnt_tick) begin
      cnt_d = (periodic && cmp_hit) ? '0 : cnt_q + CNT_W'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_comb begin
    pval_d = pval_q;
    pend_d = pend_q;
    if (cnt_wr) begin
      pval_d = wdata;
      pend_d = PEND_START;
    end else if (slow_tick && (pend_q != '0)) begin
      pend_d = pend_q - PEND_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pval_q <= '0;
      pend_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pval_q <= pval_d;
      pend_q <= pend_d;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !load_now) |=> $stable(cnt_q));

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !load_now && periodic && cmp_hit) |=> (cnt_q == '0));

  // R7
  pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (pend_q == PEND_START));

  // R13
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (cnt_q == $past(pval_q)));

endmodule

// File: rtl/cmt_regs.sv
module cmt_regs
  import cmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [CNT_W-1:0] wdata,
  input  logic             match_evt,
  input  logic             ovf_evt,
  output ctrl_t            ctrl_q,
  output logic             mf_q,
  output logic             of_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             irq,
  output logic             dma_req
);

  logic             csr_wr, cmp_wr;
  ctrl_t            ctrl_d;
  logic             mf_d, of_d, dma_d;
  logic [CNT_W-1:0] cmp_d;

  assign csr_wr = wr_en && (sel == REG_CSR);
  assign cmp_wr = wr_en && (sel == REG_CMP);

  always_comb begin
    ctrl_d = ctrl_q;
    mf_d   = mf_q;
    of_d   = of_q;
    cmp_d  = cmp_q;
    if (csr_wr) begin
      ctrl_d.periodic = wdata[PER_BIT];
      ctrl_d.irq_en   = wdata[IE_BIT];
      ctrl_d.route    = route_e'(wdata[ROUTE_LSB +: 2]);
      ctrl_d.cks      = wdata[CKS_LSB +: 3];
      mf_d            = mf_q & wdata[MF_BIT];
      of_d            = of_q & wdata[OF_BIT];
    end
    // A hardware event outranks a software clear in the same cycle.
    mf_d = mf_d | match_evt;
    of_d = of_d | ovf_evt;
    if (cmp_wr) begin
      cmp_d = wdata;
    end
  end

  assign dma_d = match_evt && (ctrl_q.route == ROUTE_DMA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      mf_q    <= 1'b0;
      of_q    <= 1'b0;
      cmp_q   <= '1;
      dma_req <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      mf_q    <= mf_d;
      of_q    <= of_d;
      cmp_q   <= cmp_d;
      dma_req <= dma_d;
    end
  end

  assign irq = mf_q & ctrl_q.irq_en & (ctrl_q.route == ROUTE_IRQ);

  // R6
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_q && !csr_wr) |=> mf_q);

  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> of_q);

  // R9
  dma_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> ($past(match_evt) && ($past(ctrl_q.route) == ROUTE_DMA)));

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> mf_q);

endmodule

// File: rtl/cmatch_timer.sv
module cmatch_timer
  import cmt_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int LOAD_TICKS = 2,
  parameter int LOG2_A     = 3,
  parameter int LOG2_B     = 5,
  parameter int LOG2_C     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             slow_tick,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq,
  output logic             dma_req
);

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  reg_sel_e         sel;
  ctrl_t            ctrl_q;
  logic             mf_q, of_q;
  logic [CNT_W-1:0] cmp_q, cnt_q;
  logic             cnt_tick, match_evt, ovf_evt;
  logic [CSR_W-1:0] csr_val;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  assign sel = reg_sel_e'(addr);

  cmt_prescaler #(
    .LOG2_A(LOG2_A),
    .LOG2_B(LOG2_B),
    .LOG2_C(LOG2_C)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run_en   (run_en),
    .slow_tick(slow_tick),
    .cks      (ctrl_q.cks),
    .cnt_tick (cnt_tick)
  );

  cmt_counter #(
    .CNT_W     (CNT_W),
    .LOAD_TICKS(LOAD_TICKS)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .cnt_tick (cnt_tick),
    .slow_tick(slow_tick),
    .periodic (ctrl_q.periodic),
    .cnt_wr   (wr_en && (sel == REG_CNT)),
    .wdata    (wdata),
    .cmp      (cmp_q),
    .cnt_q    (cnt_q),
    .match_evt(match_evt),
    .ovf_evt  (ovf_evt)
  );

  cmt_regs #(
    .CNT_W(CNT_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (wr_en),
    .sel      (sel),
    .wdata    (wdata),
    .match_evt(match_evt),
    .ovf_evt  (ovf_evt),
    .ctrl_q   (ctrl_q),
    .mf_q     (mf_q),
    .of_q     (of_q),
    .cmp_q    (cmp_q),
    .irq      (irq),
    .dma_req  (dma_req)
  );

  always_comb begin
    csr_val                   = '0;
    csr_val[MF_BIT]           = mf_q;
    csr_val[OF_BIT]           = of_q;
    csr_val[PER_BIT]          = ctrl_q.periodic;
    csr_val[IE_BIT]           = ctrl_q.irq_en;
    csr_val[ROUTE_LSB +: 2]   = ctrl_q.route;
    csr_val[CKS_LSB +: 3]     = ctrl_q.cks;
  end

  always_comb begin
    case (sel)
      REG_CSR: rdata = CNT_W'(csr_val);
      REG_CNT: rdata = cnt_q;
      REG_CMP: rdata = cmp_q;
      default: rdata = '0;
    endcase
  end

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq |-> (mf_q && (ctrl_q.route == ROUTE_IRQ)));

endmodule

// File: tb/cmatch_timer_test.sv
module cmatch_timer_test;

  logic        clk;
  logic        rst_n;
  logic        run_en;
  logic        slow_tick;
  logic        wr_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  logic        dma_req;

  int    checks;
  int    fails;
  bit    chk_en;
  string cur_req;

  cmatch_timer uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .slow_tick(slow_tick),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .irq      (irq),
    .dma_req  (dma_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- bench model built from the requirements ----------------
  logic [31:0] m_cnt, m_cmp, m_pval;
  logic        m_mf, m_of, m_per, m_ie, m_dma;
  logic [1:0]  m_route, m_pend;
  logic [2:0]  m_cks;
  logic [6:0]  m_pre;
  logic        t_tk, t_ld, t_mt, t_ov;
  logic [31:0] t_cnt;

  function automatic logic tick_sel(input logic [2:0] cks, input logic [6:0] pre);
    case (cks)
      3'd4:    return pre[2:0] == 3'h7;
      3'd5:    return pre[4:0] == 5'h1F;
      3'd6:    return pre == 7'h7F;
      3'd7:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_csr();
    return {16'h0, m_mf, m_of, 5'b0, m_per, m_ie, 1'b0, m_route, 1'b0, m_cks};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return exp_csr();
      2'd1:    return m_cnt;
      2'd2:    return m_cmp;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 32'hFFFF_FFFF; m_pval = 0;
      m_mf = 0; m_of = 0; m_per = 0; m_ie = 0; m_dma = 0;
      m_route = 0; m_pend = 0; m_cks = 0; m_pre = 0;
    end else begin
      t_tk = run_en && slow_tick && tick_sel(m_cks, m_pre);
      t_ld = slow_tick && (m_pend == 2'd1);
      t_mt = t_tk && !t_ld && (m_cnt == m_cmp);
      t_ov = t_tk && !t_ld && (m_cnt == 32'hFFFF_FFFF) && !(m_per && m_cnt == m_cmp);
      if (t_ld)      t_cnt = m_pval;
      else if (t_tk) t_cnt = (m_per && m_cnt == m_cmp) ? 32'h0 : m_cnt + 32'h1;
      else           t_cnt = m_cnt;
      m_dma = t_mt && (m_route == 2'b01);
      if (wr_en && addr == 2'd0) begin
        m_mf = m_mf & wdata[15];
        m_of = m_of & wdata[14];
        m_per = wdata[8]; m_ie = wdata[7]; m_route = wdata[5:4]; m_cks = wdata[2:0];
      end
      m_mf = m_mf | t_mt;
      m_of = m_of | t_ov;
      if (wr_en && addr == 2'd2) m_cmp = wdata;
      if (wr_en && addr == 2'd1) begin
        m_pend = 2'd2; m_pval = wdata;
      end else if (slow_tick && m_pend != 2'd0) begin
        m_pend = m_pend - 2'd1;
      end
      m_pre = !run_en ? 7'd0 : (slow_tick ? m_pre + 7'd1 : m_pre);
      m_cnt = t_cnt;
    end
  end

  // ---------------- checking ----------------
  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      check(cur_req, "rdata", rdata, exp_rd(addr));
      check(cur_req, "irq", {31'h0, irq}, {31'h0, m_mf && m_ie && m_route == 2'b10});
      check(cur_req, "dma_req", {31'h0, dma_req}, {31'h0, m_dma});
    end
  end

  task automatic drive(input logic run, input logic slow, input logic we,
                       input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    #1;
    run_en = run; slow_tick = slow; wr_en = we; addr = a; wdata = d;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    #1;
    slow_tick = 1'b0; wr_en = 1'b0; addr = a;
    #1;
    v = rdata;
  endtask

  task automatic ticks(input logic run, input int n);
    for (int i = 0; i < n; i++) drive(run, 1'b1, 1'b0, 2'd1, 32'h0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements): actual %0d cycles, expected an earlier end", 150000);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int          ndma;
    checks = 0; fails = 0; chk_en = 0; cur_req = "R1";
    rst_n = 1'b0; run_en = 1'b0; slow_tick = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = 32'h0;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (6) @(posedge clk);
    chk_en = 1;

    // R1 reset state
    peek(2'd0, v); check("R1", "csr", v, 32'h0);
    peek(2'd1, v); check("R1", "cnt", v, 32'h0);
    peek(2'd2, v); check("R1", "cmp", v, 32'hFFFF_FFFF);
    check("R1", "irq", {31'h0, irq}, 32'h0);
    check("R1", "dma_req", {31'h0, dma_req}, 32'h0);

    // R2 hold while run_en low
    cur_req = "R2";
    drive(1'b0, 1'b0, 1'b1, 2'd0, 32'h0107);
    ticks(1'b0, 10);
    peek(2'd1, v); check("R2", "cnt held", v, 32'h0);

    // R11 clock codes 0..3 stop the counter
    cur_req = "R11";
    drive(1'b1, 1'b0, 1'b1, 2'd0, 32'h0100);
    ticks(1'b1, 10);
    peek(2'd1, v); check("R11", "cnt stopped", v, 32'h0);

    // R3 divide by 8
    cur_req = "R3";
    drive(1'b0, 1'b0, 1'b1, 2'd0, 32'h0104);
    drive(1'b0, 1'b0, 1'b1, 2'd2, 32'd1000);
    ticks(1'b1, 16);
    peek(2'd1, v); check("R3", "cnt after 16 slow ticks /8", v, 32'd2);

    // R7 delayed counter write
    cur_req = "R7";
    drive(1'b0, 1'b0, 1'b1, 2'd1, 32'd100);
    ticks(1'b0, 1);
    peek(2'd1, v); check("R7", "cnt after one tick", v, 32'd2);
    ticks(1'b0, 1);
    peek(2'd1, v); check("R7", "cnt after two ticks", v, 32'd100);

    // R13 load wins over count
    cur_req = "R13";
    drive(1'b0, 1'b0, 1'b1, 2'd0, 32'h0107);
    drive(1'b1, 1'b0, 1'b1, 2'd1, 32'd50);
    ticks(1'b1, 1);
    peek(2'd1, v); check("R13", "cnt counts while pending", v, 32'd101);
    ticks(1'b1, 1);
    peek(2'd1, v); check("R13", "load replaces count", v, 32'd50);

    // R4 periodic wrap, R8 irq
    cur_req = "R4";
    drive(1'b0, 1'b0, 1'b1, 2'd2, 32'd3);
    drive(1'b0, 1'b0, 1'b1, 2'd0, 32'h01A7);
    drive(1'b0, 1'b0, 1'b1, 2'd1, 32'd0);
    ticks(1'b0, 2);
    ticks(1'b1, 3);
    peek(2'd1, v); check("R4", "cnt at compare", v, 32'd3);
    ticks(1'b1, 1);
    peek(2'd1, v); check("R4", "cnt wrapped", v, 32'd0);
    peek(2'd0, v); check("R4", "match flag", v, 32'h81A7);
    check("R8", "irq level", {31'h0, irq}, 32'h1);

    // R6 write-one keeps, write-zero clears
    cur_req = "R6";
    drive(1'b0, 1'b0, 1'b1, 2'd0, 32'h81A7);
    peek(2'd0, v); check("R6", "flag kept", v, 32'h81A7);
    drive(1'b0, 1'b0, 1'b1, 2'd0, 32'h01A7);
    peek(2'd0, v); check("R6", "flag cleared", v, 32'h01A7);
    check("R6", "irq after clear", {31'h0, irq}, 32'h0);

    // R12 set beats clear in the same cycle
    cur_req = "R12";
    ticks(1'b1, 7);
    drive(1'b1, 1'b1, 1'b1, 2'd0, 32'h01A7);
    peek(2'd0, v); check("R12", "flag after collision", v, 32'h81A7);

    // R9 DMA pulses
    cur_req = "R9";
    drive(1'b0, 1'b0, 1'b1, 2'd0, 32'h0117);
    ndma = 0;
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, 1'b1, 1'b0, 2'd1, 32'h0);
      @(posedge clk);
      #1;
      if (dma_req) ndma++;
    end
    check("R9", "dma pulses in 8 ticks", ndma, 2);
    check("R8", "irq off with DMA routing", {31'h0, irq}, 32'h0);

    // R10 all-zero write
    cur_req = "R10";
    drive(1'b0, 1'b0, 1'b1, 2'd0, 32'h81A7);
    peek(2'd0, v); check("R8", "irq with routing restored", {31'h0, irq}, 32'h1);
    drive(1'b0, 1'b0, 1'b1, 2'd0, 32'h0);
    peek(2'd0, v); check("R10", "csr zero", v, 32'h0);
    check("R10", "irq off", {31'h0, irq}, 32'h0);
    ticks(1'b1, 5);
    check("R10", "dma off", {31'h0, dma_req}, 32'h0);

    // R5 free-running match and overflow
    cur_req = "R5";
    drive(1'b0, 1'b0, 1'b1, 2'd2, 32'hFFFF_FFF2);
    drive(1'b0, 1'b0, 1'b1, 2'd0, 32'h00A7);
    drive(1'b0, 1'b0, 1'b1, 2'd1, 32'hFFFF_FFF0);
    ticks(1'b0, 2);
    ticks(1'b1, 3);
    peek(2'd1, v); check("R5", "cnt past compare", v, 32'hFFFF_FFF3);
    peek(2'd0, v); check("R5", "match flag free-run", v, 32'h80A7);
    ticks(1'b1, 13);
    peek(2'd1, v); check("R5", "cnt rolled over", v, 32'h0);
    peek(2'd0, v); check("R5", "overflow flag", v, 32'hC0A7);

    // Random mix checked against the model every cycle
    cur_req = "R3 R4 R5 R9 R12 R13 random";
    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  a;
      logic [31:0] d;
      a = 2'($urandom % 4);
      case (a)
        2'd0: begin
          d = $urandom & 32'h0000_C1B0;
          d[2:0] = ($urandom % 5 == 0) ? 3'($urandom % 4) : 3'(4 + $urandom % 4);
        end
        2'd1: d = ($urandom % 4 == 0) ? 32'hFFFF_FFF0 + ($urandom % 16) : ($urandom % 24);
        default: d = $urandom % 24;
      endcase
      drive(($urandom % 10) != 0, 1'($urandom % 2), ($urandom % 8) == 0, a, d);
    end
    drive(1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
    @(negedge clk);
    chk_en = 0;

    summary();
    $finish;
  end

endmodule